// File: doc/BRIEF.md
# Cell transmit retry controller

This block sequences the transmission of queued cells towards a switch fabric, one action per frame slot. Software, or an upstream queue, hands it a transmit descriptor made of a buffer number, a retry limit and a discard flag. The block holds that descriptor until the next frame pulse. It then either sends the cell or, for a discard-marked descriptor, hands the buffer straight back to the free queue without sending anything.

After a send the fabric answers with an acknowledge or a negative acknowledge. An acknowledge finishes the cell and returns its buffer. A negative acknowledge queues the same cell for another attempt at a later frame pulse. When the number of negative acknowledges reaches the descriptor's retry limit, the block stops accepting work and raises an interrupt. Clearing the interrupt drops the failed cell, frees its buffer and reopens the descriptor input.

Top module: `cell_tx_retry`

## Requirements
- R1: Out of reset, `desc_ready` is 1 and `send_valid`, `free_valid` and `irq` are 0.
- R2: `desc_ready` is 1 only while no cell is held. A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both 1, and `desc_ready` then stays 0 until that cell is finished.
- R3: With a non-discard cell held, a `frame_pulse` sampled on an edge makes `send_valid` 1 for exactly the following cycle, with `send_buf` equal to the held buffer number. Frame pulses that arrive while a reply is awaited cause no action.
- R4: An acknowledge (`fab_ack`=1) while a reply is awaited makes `free_valid` 1 for the next cycle, with `free_buf` equal to the held buffer, and `desc_ready` returns to 1 in that same cycle.
- R5: A negative acknowledge (`fab_nack`=1) that leaves the NACK count below the retry limit sends the same buffer again at the next frame pulse.
- R6: When the NACK count for the held cell reaches its retry limit, `irq` goes to 1 in the next cycle and stays 1 until cleared. While it is 1, no cell is sent and `desc_ready` is 0. A retry limit of 0 halts on the first NACK.
- R7: Setting `irq_clr` to 1 while `irq` is 1 clears `irq` in the next cycle and, in that same cycle, returns the failed buffer with a one-cycle `free_valid`.
- R8: A descriptor with `desc_discard`=1 is never sent. At the first frame pulse after it is taken, its buffer is returned with `free_valid`. The next descriptor then waits for a later frame pulse of its own.
- R9: The NACK count restarts at zero for every descriptor taken, so each cell gets its full retry budget. The count saturates at its maximum.
- R10: `fab_ack` and `fab_nack` have no effect unless a reply is awaited, and `irq_clr` has no effect unless `irq` is 1.
- R11: If `fab_ack` and `fab_nack` are both 1 on the same edge, the acknowledge wins and the cell completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block can take a descriptor |
| desc_buf | input | BUF_W | Buffer number of the offered cell |
| desc_retry | input | RETRY_W | Retry limit (NACKs tolerated) |
| desc_discard | input | 1 | Return buffer without sending |
| frame_pulse | input | 1 | One-cycle frame slot marker |
| send_valid | output | 1 | One-cycle send strobe to the fabric |
| send_buf | output | BUF_W | Buffer number being sent |
| fab_ack | input | 1 | Fabric accepted the cell |
| fab_nack | input | 1 | Fabric rejected the cell |
| free_valid | output | 1 | One-cycle free-queue return strobe |
| free_buf | output | BUF_W | Buffer number being returned |
| irq | output | 1 | Retry limit exhausted, engine halted |
| irq_clr | input | 1 | Clears the interrupt and drops the cell |

## Verification
The bench builds the block with its default 8-bit buffer number and 4-bit retry field. With these widths, the retry limits used (0, 2 and 3) reach exhaustion within a few frame slots. Distinct buffer numbers per descriptor show which cell a send or free strobe belongs to. Keeping the retry field narrow lets the zero-limit case and the counter restart between descriptors be exercised in a short run.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

    typedef enum logic [1:0] {
        TXS_IDLE = 2'd0,
        TXS_SLOT = 2'd1,
        TXS_RESP = 2'd2,
        TXS_HALT = 2'd3
    } txs_state_e;

    typedef struct packed {
        txs_state_e state;
        logic       send;
        logic       free;
        logic       irq;
    } txs_regs_t;

endpackage

// File: rtl/txr_nack_ctr.sv
module txr_nack_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             exhaust
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] bumped;

    always_comb begin
        bumped = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        cnt_d  = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = bumped;
        end
        exhaust = (bumped >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import cell_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic discard,
    input  logic frame_pulse,
    input  logic ack,
    input  logic nack,
    input  logic irq_clr,
    input  logic exhaust,
    output logic ctr_clr,
    output logic ctr_inc,
    output logic idle,
    output logic send_strobe,
    output logic free_strobe,
    output logic irq
);
    txs_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.send = 1'b0;
        r_d.free = 1'b0;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        unique case (r_q.state)
            TXS_IDLE: begin
                if (load) begin
                    ctr_clr   = 1'b1;
                    r_d.state = TXS_SLOT;
                end
            end
            TXS_SLOT: begin
                if (frame_pulse) begin
                    if (discard) begin
                        r_d.free  = 1'b1;
                        r_d.state = TXS_IDLE;
                    end else begin
                        r_d.send  = 1'b1;
                        r_d.state = TXS_RESP;
                    end
                end
            end
            TXS_RESP: begin
                if (ack) begin
                    ctr_clr   = 1'b1;
                    r_d.free  = 1'b1;
                    r_d.state = TXS_IDLE;
                end else if (nack) begin
                    ctr_inc = 1'b1;
                    if (exhaust) begin
                        r_d.irq   = 1'b1;
                        r_d.state = TXS_HALT;
                    end else begin
                        r_d.state = TXS_SLOT;
                    end
                end
            end
            TXS_HALT: begin
                if (irq_clr) begin
                    ctr_clr   = 1'b1;
                    r_d.irq   = 1'b0;
                    r_d.free  = 1'b1;
                    r_d.state = TXS_IDLE;
                end
            end
            default: r_d.state = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: TXS_IDLE, send: 1'b0, free: 1'b0, irq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign idle        = (r_q.state == TXS_IDLE);
    assign send_strobe = r_q.send;
    assign free_strobe = r_q.free;
    assign irq         = r_q.irq;
endmodule

// File: rtl/cell_tx_retry.sv
module cell_tx_retry #(
    parameter int BUF_W   = 8,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [BUF_W-1:0]   desc_buf,
    input  logic [RETRY_W-1:0] desc_retry,
    input  logic               desc_discard,
    input  logic               frame_pulse,
    output logic               send_valid,
    output logic [BUF_W-1:0]   send_buf,
    input  logic               fab_ack,
    input  logic               fab_nack,
    output logic               free_valid,
    output logic [BUF_W-1:0]   free_buf,
    output logic               irq,
    input  logic               irq_clr
);
    typedef struct packed {
        logic [BUF_W-1:0]   bufn;
        logic [RETRY_W-1:0] retry;
        logic               discard;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  load, idle, ctr_clr, ctr_inc, exhaust;

    assign desc_ready = idle;
    assign load       = desc_valid & idle;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.bufn    = desc_buf;
            hold_d.retry   = desc_retry;
            hold_d.discard = desc_discard;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    txr_nack_ctr #(.CNT_W(RETRY_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .limit   (hold_q.retry),
        .exhaust (exhaust)
    );

    txr_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .discard     (hold_q.discard),
        .frame_pulse (frame_pulse),
        .ack         (fab_ack),
        .nack        (fab_nack),
        .irq_clr     (irq_clr),
        .exhaust     (exhaust),
        .ctr_clr     (ctr_clr),
        .ctr_inc     (ctr_inc),
        .idle        (idle),
        .send_strobe (send_valid),
        .free_strobe (free_valid),
        .irq         (irq)
    );

    assign send_buf = hold_q.bufn;
    assign free_buf = hold_q.bufn;
endmodule

// File: rtl/cell_tx_retry_chk.sv
module cell_tx_retry_chk #(
    parameter int BUF_W   = 8,
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               desc_valid,
    input logic               desc_ready,
    input logic [BUF_W-1:0]   desc_buf,
    input logic [RETRY_W-1:0] desc_retry,
    input logic               desc_discard,
    input logic               frame_pulse,
    input logic               send_valid,
    input logic [BUF_W-1:0]   send_buf,
    input logic               fab_ack,
    input logic               fab_nack,
    input logic               free_valid,
    input logic [BUF_W-1:0]   free_buf,
    input logic               irq,
    input logic               irq_clr
);
    AST_SEND_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid |-> $past(frame_pulse)); // R3

    AST_SEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid |=> !send_valid); // R3

    AST_NO_SEND_AND_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_valid && free_valid)); // R8

    AST_FREE_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> desc_ready); // R4

    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!desc_ready && !send_valid)); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R6

    AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr) |=> (free_valid && !irq)); // R7

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready) |=> !desc_ready); // R2
endmodule

bind cell_tx_retry cell_tx_retry_chk #(.BUF_W(BUF_W), .RETRY_W(RETRY_W)) chk_i (.*);

// File: tb/cell_tx_retry_tb_top.sv
module cell_tx_retry_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUF_W      = 8;
    localparam int RETRY_W    = 4;
    localparam logic [1:0] EV_SEND = 2'd0;
    localparam logic [1:0] EV_FREE = 2'd1;
    localparam logic [1:0] EV_IRQ  = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_valid = 1'b0;
    logic [BUF_W-1:0] desc_buf = '0;
    logic [RETRY_W-1:0] desc_retry = '0;
    logic desc_discard = 1'b0;
    logic frame_pulse = 1'b0;
    logic fab_ack = 1'b0;
    logic fab_nack = 1'b0;
    logic irq_clr = 1'b0;
    logic desc_ready, send_valid, free_valid, irq;
    logic [BUF_W-1:0] send_buf, free_buf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [BUF_W+1:0] exp_q[$];
    logic irq_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_tx_retry #(.BUF_W(BUF_W), .RETRY_W(RETRY_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_buf(desc_buf), .desc_retry(desc_retry), .desc_discard(desc_discard),
        .frame_pulse(frame_pulse),
        .send_valid(send_valid), .send_buf(send_buf),
        .fab_ack(fab_ack), .fab_nack(fab_nack),
        .free_valid(free_valid), .free_buf(free_buf),
        .irq(irq), .irq_clr(irq_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_ev(input logic [1:0] kind, input logic [BUF_W-1:0] b);
        exp_q.push_back({kind, b});
    endtask

    task automatic observe(input logic [1:0] kind, input logic [BUF_W-1:0] b);
        logic [BUF_W+1:0] got, want;
        got = {kind, b};
        if (exp_q.size() == 0) begin
            check(1'b0, "R3/R8/R10 unexpected event", int'(got), 0);
        end else begin
            want = exp_q.pop_front();
            check(got == want, "R3-R11 event order", int'(got), int'(want));
        end
    endtask

    // monitor: samples registered outputs at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (send_valid) observe(EV_SEND, send_buf);
            if (free_valid) observe(EV_FREE, free_buf);
            if (irq && !irq_prev) observe(EV_IRQ, '0);
        end
        irq_prev <= irq;
    end

    task automatic load(input logic [BUF_W-1:0] b, input logic [RETRY_W-1:0] r, input bit d);
        @(negedge clk);
        desc_valid = 1'b1; desc_buf = b; desc_retry = r; desc_discard = d;
        @(negedge clk);
        desc_valid = 1'b0;
        check(desc_ready == 1'b0, "R2 busy after take", desc_ready, 0);
    endtask

    task automatic frame();
        @(negedge clk); frame_pulse = 1'b1;
        @(negedge clk); frame_pulse = 1'b0;
    endtask

    task automatic reply(input bit a, input bit n);
        @(negedge clk); fab_ack = a; fab_nack = n;
        @(negedge clk); fab_ack = 1'b0; fab_nack = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(desc_ready == 1'b1, "R1 ready", desc_ready, 1);
        check(send_valid == 1'b0, "R1 send", send_valid, 0);
        check(free_valid == 1'b0, "R1 free", free_valid, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R10: ack / nack / clear while idle do nothing
        reply(1'b1, 1'b0);
        reply(1'b0, 1'b1);
        clear();
        idle_cycles(2);
        check(desc_ready == 1'b1 && irq == 1'b0, "R10 idle ignores", {desc_ready, irq}, 2);

        // R3/R4: plain send and ack; extra frame pulse while awaiting ignored
        load(8'h11, 4'd2, 1'b0);
        expect_ev(EV_SEND, 8'h11);
        frame();
        frame();
        check(desc_ready == 1'b0, "R3 awaiting reply", desc_ready, 0);
        expect_ev(EV_FREE, 8'h11);
        reply(1'b1, 1'b0);
        check(desc_ready == 1'b1, "R4 ready after ack", desc_ready, 1);

        // R5/R6/R7: retry then halt at limit 2, clear frees buffer
        load(8'h22, 4'd2, 1'b0);
        expect_ev(EV_SEND, 8'h22);
        frame();
        reply(1'b0, 1'b1);
        check(irq == 1'b0, "R5 no halt below limit", irq, 0);
        expect_ev(EV_SEND, 8'h22);
        frame();
        expect_ev(EV_IRQ, 8'h00);
        reply(1'b0, 1'b1);
        check(irq == 1'b1, "R6 irq at limit", irq, 1);
        check(desc_ready == 1'b0, "R6 ready low in halt", desc_ready, 0);
        frame();
        idle_cycles(3);
        check(irq == 1'b1, "R6 irq sticky", irq, 1);
        expect_ev(EV_FREE, 8'h22);
        clear();
        check(irq == 1'b0, "R7 irq cleared", irq, 0);
        check(desc_ready == 1'b1, "R7 ready after clear", desc_ready, 1);

        // R6: retry limit 0 halts on first NACK
        load(8'h33, 4'd0, 1'b0);
        expect_ev(EV_SEND, 8'h33);
        frame();
        expect_ev(EV_IRQ, 8'h00);
        reply(1'b0, 1'b1);
        check(irq == 1'b1, "R6 zero limit halts", irq, 1);
        expect_ev(EV_FREE, 8'h33);
        clear();

        // R9: two NACKs then ack; next cell with limit 3 survives two NACKs
        load(8'h44, 4'd3, 1'b0);
        expect_ev(EV_SEND, 8'h44); frame(); reply(1'b0, 1'b1);
        expect_ev(EV_SEND, 8'h44); frame(); reply(1'b0, 1'b1);
        expect_ev(EV_SEND, 8'h44); frame();
        expect_ev(EV_FREE, 8'h44); reply(1'b1, 1'b0);
        load(8'h55, 4'd3, 1'b0);
        expect_ev(EV_SEND, 8'h55); frame(); reply(1'b0, 1'b1);
        expect_ev(EV_SEND, 8'h55); frame(); reply(1'b0, 1'b1);
        check(irq == 1'b0, "R9 fresh retry budget", irq, 0);
        expect_ev(EV_SEND, 8'h55); frame();
        expect_ev(EV_FREE, 8'h55); reply(1'b1, 1'b0);

        // R8: discard frees without send; next cell needs its own frame pulse
        load(8'h66, 4'd5, 1'b1);
        idle_cycles(2);
        expect_ev(EV_FREE, 8'h66);
        frame();
        check(desc_ready == 1'b1, "R8 ready after discard", desc_ready, 1);
        load(8'h99, 4'd1, 1'b0);
        idle_cycles(3);
        check(exp_q.size() == 0, "R8 next waits for frame", exp_q.size(), 0);
        expect_ev(EV_SEND, 8'h99); frame();
        expect_ev(EV_FREE, 8'h99); reply(1'b1, 1'b0);

        // R10: reply before send is ignored
        load(8'h77, 4'd0, 1'b0);
        reply(1'b0, 1'b1);
        reply(1'b1, 1'b0);
        check(irq == 1'b0 && desc_ready == 1'b0, "R10 early reply ignored", {irq, desc_ready}, 0);
        expect_ev(EV_SEND, 8'h77); frame();
        expect_ev(EV_FREE, 8'h77); reply(1'b1, 1'b0);

        // R11: ack and nack together, ack wins even with limit 0
        load(8'h88, 4'd0, 1'b0);
        expect_ev(EV_SEND, 8'h88); frame();
        expect_ev(EV_FREE, 8'h88); reply(1'b1, 1'b1);
        check(irq == 1'b0, "R11 ack precedence", irq, 0);

        idle_cycles(4);
        check(exp_q.size() == 0, "R3-R11 all expected events seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule